// File: doc/BRIEF.md
# Laplacian Sub-Scan Image Sharpener

This block sharpens a raster image in the vertical (line-to-line) direction only. Pixels arrive one per accepted strobe, in raster order, and a line-start marker flags the first pixel of each scan line. Two cascaded whole-line delays are indexed by column. For every incoming pixel the block can therefore see the pixel at the same column one line earlier (the centre pixel, N) and two lines earlier (A), as well as the incoming pixel itself (B).

The output is the centre pixel raised by a gain times its second difference against its two vertical neighbours. This is N + K*(2N - (A+B)). The product is rounded to an integer and the result is clamped to the pixel range. The arithmetic runs through a three-register pipeline. Each accepted pixel from the third line onward produces one output a fixed number of cycles later. Line length, pixel width and the fixed-point format of the gain are parameters.

Top module: `subscan_sharpen`

## Requirements
- R1: While reset is held and immediately after it, `out_valid` is low and `out_pix` is zero.
- R2: Every accepted pixel that is eligible for output produces exactly one output, in input order. `out_valid` for it is high in the cycle after the third rising edge, counting the edge that sampled the input as the first.
- R3: A valid pixel with `in_sol` high begins a new line at column 0. Pixels of the first two lines after reset, and any pixels before the first line start, produce no output. From the third line start onward, every valid pixel produces an output.
- R4: For column c, B is the incoming pixel, N is the pixel last written at column c one line earlier, and A is the one two lines earlier. `gain` is unsigned with 4 integer and 4 fraction bits (value = gain/16) and is sampled together with the pixel. The output is clamp(N + round(gain*(2N-A-B)/16)).
- R5: Rounding adds 8 to the product gain*(2N-A-B) and then floor-divides by 16, so halves round up. With 2N-A-B = 1 and gain = 8 the output is N+1. With 2N-A-B = -1 and gain = 8 the output is N.
- R6: A negative result is output as 0, and a result above 255 is output as 255.
- R7: A cycle with `in_valid` low samples nothing. It does not advance the column and takes no output slot.
- R8: After LINE_LEN pixels without a line start, the column returns to 0. This wrap does not count as a new line.
- R9: A line start that arrives before LINE_LEN pixels restarts at column 0. Columns that the short line did not reach keep the pixels written there earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sol | input | 1 | Marks the first pixel of a line (qualified by in_valid) |
| in_pix | input | PIX_W | Incoming pixel (next line, B) |
| gain | input | GAIN_INT+GAIN_FRAC | Unsigned fixed-point sharpening gain |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | PIX_W | Sharpened, clamped pixel |

## Verification
Some properties are checked by assertions on every cycle:
- an output strobe always traces back to an input strobe three cycles earlier;
- ineligible pixels never yield an output;
- the column index stays inside the line;
- a zero gain passes the centre pixel through unchanged;
- a non-negative correction never lowers the pixel.

Other behaviours show up only in the bench's scenarios, where a model keeps its own pair of line buffers:
- the exact sharpened values;
- rounding of ties at both signs;
- clamping at both ends;
- column wrap on over-long lines;
- old data persisting behind a short line;
- idle gaps inside a line.

// File: rtl/sharpen_pkg.sv
package sharpen_pkg;

   // number of whole-line delays in the vertical window
   localparam int NUM_LINE_DLY = 2;

   // line starts needed before the window holds three real lines
   localparam int LINES_TO_FILL = NUM_LINE_DLY + 1;

   // width of a saturating line counter able to reach LINES_TO_FILL
   localparam int LINE_CNT_W = $clog2(LINES_TO_FILL + 1);

   // signed width of 2N-(A+B) for a pixel of width w
   function automatic int diff_width(input int w);
      return w + 2;
   endfunction

endpackage

// File: rtl/sharpen_linepos.sv
module sharpen_linepos
   import sharpen_pkg::*;
#(
   parameter int LINE_LEN = 1024,
   localparam int COL_W   = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sol,
   output logic [COL_W-1:0] col,
   output logic             elig
);

   localparam logic [COL_W-1:0]      LAST_COL = COL_W'(LINE_LEN - 1);
   localparam logic [LINE_CNT_W-1:0] FULL     = LINE_CNT_W'(LINES_TO_FILL);

   logic [COL_W-1:0]      col_q;
   logic [LINE_CNT_W-1:0] lines_q;
   logic                  sol_hit;

   assign sol_hit = in_valid && in_sol;
   assign col     = in_sol ? '0 : col_q;
   assign elig    = (lines_q == FULL) ||
                    (sol_hit && (lines_q == FULL - LINE_CNT_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q   <= '0;
         lines_q <= '0;
      end else if (in_valid) begin
         col_q <= (col == LAST_COL) ? '0 : col + COL_W'(1);
         if (in_sol && lines_q != FULL)
            lines_q <= lines_q + LINE_CNT_W'(1);
      end
   end

   // R8
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= LAST_COL);

   // R3
   line_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> lines_q >= $past(lines_q));

endmodule

// File: rtl/sharpen_linedly.sv
module sharpen_linedly #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1024,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] store [DEPTH];

   // read returns the value left by the previous line at this column
   assign dout = store[addr];

   always_ff @(posedge clk) begin
      if (wr_en)
         store[addr] <= din;
   end

endmodule

// File: rtl/sharpen_kernel.sv
module sharpen_kernel
   import sharpen_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int GAIN_INT  = 4,
   parameter int GAIN_FRAC = 4,
   localparam int K_W      = GAIN_INT + GAIN_FRAC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [PIX_W-1:0] pix_a,
   input  logic [PIX_W-1:0] pix_n,
   input  logic [PIX_W-1:0] pix_b,
   input  logic [K_W-1:0]   gain,
   output logic             out_vld,
   output logic [PIX_W-1:0] out_pix
);

   localparam int D_W = diff_width(PIX_W);
   localparam int P_W = D_W + K_W + 1;
   localparam int S_W = P_W + 1;
   localparam logic signed [S_W-1:0] PIX_MAX = S_W'((1 << PIX_W) - 1);

   // stage 1: second difference
   logic                    v1;
   logic signed [D_W-1:0]   d1;
   logic [PIX_W-1:0]        n1;
   logic [K_W-1:0]          k1;
   logic [D_W-1:0]          twice_n;
   logic [D_W-1:0]          pair_sum;
   logic signed [D_W-1:0]   diff_c;

   assign twice_n  = {1'b0, pix_n, 1'b0};
   assign pair_sum = {2'b00, pix_a} + {2'b00, pix_b};
   assign diff_c   = $signed(twice_n) - $signed(pair_sum);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         d1 <= '0;
         n1 <= '0;
         k1 <= '0;
      end else begin
         v1 <= in_vld;
         if (in_vld) begin
            d1 <= diff_c;
            n1 <= pix_n;
            k1 <= gain;
         end
      end
   end

   // stage 2: gain product and rounding
   logic                  v2;
   logic signed [P_W-1:0] r2;
   logic [PIX_W-1:0]      n2;
   logic signed [P_W-1:0] prod_c;
   logic signed [P_W-1:0] rnd_c;

   assign prod_c = P_W'(d1) * $signed({{(P_W-K_W){1'b0}}, k1});

   if (GAIN_FRAC > 0) begin : g_round
      localparam logic signed [P_W-1:0] HALF = P_W'(1 << (GAIN_FRAC - 1));
      assign rnd_c = (prod_c + HALF) >>> GAIN_FRAC;
   end else begin : g_whole
      assign rnd_c = prod_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2 <= 1'b0;
         r2 <= '0;
         n2 <= '0;
      end else begin
         v2 <= v1;
         if (v1) begin
            r2 <= rnd_c;
            n2 <= n1;
         end
      end
   end

   // stage 3: add and clamp
   logic signed [S_W-1:0] sum_c;
   logic [PIX_W-1:0]      clip_c;

   assign sum_c = S_W'(r2) + $signed({{(S_W-PIX_W){1'b0}}, n2});

   always_comb begin
      if (sum_c[S_W-1])
         clip_c = '0;
      else if (sum_c > PIX_MAX)
         clip_c = '1;
      else
         clip_c = sum_c[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_pix <= '0;
      end else begin
         out_vld <= v2;
         if (v2)
            out_pix <= clip_c;
      end
   end

   // R4
   zero_gain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v1 && k1 == '0) |-> ##2 (out_pix == $past(n1, 2)));

   // R6
   no_lowering_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !r2[P_W-1]) |=> (out_pix >= $past(n2)));

endmodule

// File: rtl/subscan_sharpen.sv
module subscan_sharpen
   import sharpen_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int LINE_LEN  = 1024,
   parameter int GAIN_INT  = 4,
   parameter int GAIN_FRAC = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic                            in_sol,
   input  logic [PIX_W-1:0]                in_pix,
   input  logic [GAIN_INT+GAIN_FRAC-1:0]   gain,
   output logic                            out_valid,
   output logic [PIX_W-1:0]                out_pix
);

   localparam int COL_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
   localparam int K_W   = GAIN_INT + GAIN_FRAC;

   if (LINE_LEN < 2) begin : g_bad_len
      $error("LINE_LEN must be at least 2");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $error("PIX_W must be at least 2");
   end
   if (K_W < 1) begin : g_bad_gain
      $error("gain needs at least one bit");
   end

   logic [COL_W-1:0] col;
   logic             elig;

   sharpen_linepos #(.LINE_LEN(LINE_LEN)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sol   (in_sol),
      .col      (col),
      .elig     (elig)
   );

   // taps[0] = next line (B), taps[1] = centre (N), taps[2] = previous (A)
   logic [PIX_W-1:0] taps [NUM_LINE_DLY+1];
   assign taps[0] = in_pix;

   for (genvar i = 0; i < NUM_LINE_DLY; i++) begin : g_dly
      sharpen_linedly #(.DATA_W(PIX_W), .DEPTH(LINE_LEN)) u_dly (
         .clk   (clk),
         .wr_en (in_valid),
         .addr  (col),
         .din   (taps[i]),
         .dout  (taps[i+1])
      );
   end

   sharpen_kernel #(
      .PIX_W     (PIX_W),
      .GAIN_INT  (GAIN_INT),
      .GAIN_FRAC (GAIN_FRAC)
   ) u_math (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_valid && elig),
      .pix_a   (taps[NUM_LINE_DLY]),
      .pix_n   (taps[1]),
      .pix_b   (taps[0]),
      .gain    (gain[K_W-1:0]),
      .out_vld (out_valid),
      .out_pix (out_pix)
   );

   // R2
   out_from_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3));

   // R3
   no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && elig) |-> ##3 !out_valid);

endmodule

// File: tb/sim_subscan_sharpen.sv
module sim_subscan_sharpen;

   localparam int L = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sol = 1'b0;
   logic [7:0] in_pix = '0;
   logic [7:0] gain = '0;
   logic       out_valid;
   logic [7:0] out_pix;

   always #2 clk = ~clk;

   subscan_sharpen #(.LINE_LEN(L)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sol    (in_sol),
      .in_pix    (in_pix),
      .gain      (gain),
      .out_valid (out_valid),
      .out_pix   (out_pix)
   );

   typedef struct {
      int    val;
      int    cyc;
      string tag;
   } exp_t;

   exp_t  exp_q[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   int    n_out = 0;
   int    buf_n [L];
   int    buf_a [L];
   int    col = 0;
   int    col_nxt = 0;
   int    lines = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act,
                        input int expv, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && out_valid) begin
         n_out++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", int'(out_pix), -1, "output with nothing expected");
         end else begin
            e = exp_q.pop_front();
            check(int'(out_pix) == e.val, e.tag, int'(out_pix), e.val, "pixel value");
            check(cyc == e.cyc, "R2", cyc, e.cyc, "output cycle");
         end
      end
   end

   // driver: one pixel, with reference model per the requirements
   task automatic px(input bit sol, input int pix, input int g, input string tag);
      int a, n, b, d, p, r, s;
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = sol;
      in_pix   = pix[7:0];
      gain     = g[7:0];
      b = pix & 255;
      if (sol) begin
         col = 0;
         if (lines < 3) lines++;
      end else begin
         col = col_nxt;
      end
      col_nxt = (col == L - 1) ? 0 : col + 1;
      a = buf_a[col];
      n = buf_n[col];
      buf_a[col] = n;
      buf_n[col] = b;
      if (lines >= 3) begin
         d = 2 * n - a - b;
         p = d * (g & 255);
         r = (p + 8) >>> 4;
         s = n + r;
         if (s < 0) s = 0;
         if (s > 255) s = 255;
         e.val = s;
         e.cyc = cyc + 3;
         e.tag = tag;
         exp_q.push_back(e);
      end
   endtask

   task automatic idle(input int k);
      repeat (k) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sol   = 1'b0;
      end
   endtask

   // step < 0 selects random pixels; gap > 0 inserts an idle cycle every gap pixels
   task automatic line(input int len, input int g, input int base, input int step,
                       input int gap, input string tag);
      for (int c = 0; c < len; c++) begin
         int v;
         v = (step < 0) ? int'($urandom_range(0, 255)) : ((base + step * c) & 255);
         px(c == 0, v, g, tag);
         if (gap > 0 && (c % gap) == gap - 1) idle(1);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(7));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid in reset");
      check(out_pix == 8'd0, "R1", int'(out_pix), 0, "out_pix in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid after reset");

      // R3: stray pixels before any line start, then two filling lines
      px(1'b0, 17, 16, "R3");
      px(1'b0, 99, 16, "R3");
      px(1'b0, 200, 16, "R3");
      line(L, 16, 0, -1, 0, "R3");
      line(L, 16, 0, -1, 0, "R3");
      idle(5);
      check(n_out == 0, "R3", n_out, 0, "outputs during fill lines");

      // R4: general arithmetic with several gains
      line(L, 16, 0, -1, 0, "R4");
      line(L, 8'h23, 0, -1, 0, "R4");
      line(L, 8'h00, 0, -1, 0, "R4");

      // R6: clamp high then low
      line(L, 16, 0, 0, 0, "R6");
      line(L, 16, 250, 0, 0, "R6");
      line(L, 16, 0, 0, 0, "R6");
      line(L, 16, 255, 0, 0, "R6");

      // R5: ties at +1/-1 with gain one half
      line(L, 8, 10, 0, 0, "R5");
      line(L, 8, 10, 0, 0, "R5");
      line(L, 8, 9, 0, 0, "R5");
      line(L, 8, 9, 0, 0, "R5");

      // R7: idle gaps inside lines
      line(L, 8'h18, 0, -1, 3, "R7");
      line(L, 8'h18, 0, -1, 2, "R7");
      line(L, 8'h18, 0, -1, 1, "R7");

      // R8: over-long line wraps the column
      line(L + 3, 8'h14, 0, -1, 0, "R8");
      line(L, 8'h14, 0, -1, 0, "R8");

      // R9: short line leaves old data in the unreached columns
      line(L - 3, 8'h14, 0, -1, 0, "R9");
      line(L, 8'h14, 3, 7, 0, "R9");
      line(L, 8'h14, 0, -1, 0, "R9");

      // R4: maximum gain
      line(L, 255, 0, -1, 0, "R4");
      line(L, 255, 0, -1, 0, "R4");

      idle(8);
      check(exp_q.size() == 0, "R2", exp_q.size(), 0, "outputs still missing");
      done = 1'b1;
      summary();
      $finish;
   end

endmodule